// File: doc/BRIEF.md
# Upstream Request Tag and Ordering Mapper

This block sits between a graphics-port request queue and the upstream link packetizer. Each accepted request is turned into a link request descriptor. The descriptor carries a unit identifier, a source tag, a command (sized read or sized write), a channel selection and the pass-posted-write flags. Descriptors leave through a one-entry output register with a valid/ready handshake.

Non-posted requests take a tag and keep it until the response for that tag returns. Graphics reads draw tags in strict rotation over a fixed range. PCI-mode reads all share one reserved tag. The block holds one outstanding bit per tag. When the next tag is not free, it stalls a read. It accepts a low-priority fence only once every read response has returned, and the fence emits no descriptor.

Three consecutive unit identifiers starting at a programmable base belong to the block. The base itself is never used. The base plus one carries PCI-mode traffic, and the base plus two carries all graphics traffic of both priorities.

Top module: `up_req_mapper`

## Requirements
- R1: Graphics reads receive source tags 0, 1, …, NUM_TAGS-1 (27 by default) and then wrap to 0. The first graphics read after reset receives tag 0. Writes, fences and PCI-mode requests do not advance the rotation.
- R2: A graphics read is not accepted (`req_ready_o` low) while the tag it would receive is still outstanding. With all NUM_TAGS graphics tags outstanding, no graphics read is accepted.
- R3: A PCI-mode request (kind 3) yields a read descriptor with tag NUM_TAGS (28), unit ID base+1, posted 0, pass_pw 0 and rsp_pass_pw 0. While tag NUM_TAGS is outstanding, a further PCI-mode request is stalled.
- R4: Graphics descriptors (reads and writes) carry unit ID base+2, computed modulo 2^UID_W. The base value itself is never emitted.
- R5: A high-priority write (kind 1) yields cmd 1 (sized write), posted 1, pass_pw 1, rsp_pass_pw 0 and tag 0. It needs no tag and is never stalled by outstanding reads.
- R6: A high-priority read (kind 0) yields cmd 0 (sized read), posted 0, pass_pw 1 and rsp_pass_pw 1.
- R7: A low-priority fence (kind 2) is accepted only when no tag (graphics or PCI) is outstanding. An accepted fence loads no descriptor.
- R8: A response pulse on `rsp_valid_i` clears the outstanding bit of `rsp_tag_i`. A response whose tag is not outstanding, or is above NUM_TAGS, leaves all state unchanged and raises `rsp_err_o` for exactly the next cycle.
- R9: After reset, `desc_valid_o` and `rsp_err_o` are low. A descriptor appears on the cycle after acceptance. A descriptor with `desc_ready_i` low keeps all its fields stable, and requests that would emit a descriptor are then stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_uid_i | input | UID_W | Base of the three reserved unit IDs |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 0 high-priority read, 1 high-priority write, 2 low-priority fence, 3 PCI-mode read |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| rsp_valid_i | input | 1 | Response returned |
| rsp_tag_i | input | TAG_W | Tag of the returned response |
| rsp_err_o | output | 1 | Response tag was not outstanding |
| desc_valid_o | output | 1 | Descriptor present |
| desc_ready_i | input | 1 | Descriptor taken |
| desc_uid_o | output | UID_W | Unit ID |
| desc_tag_o | output | TAG_W | Source tag |
| desc_cmd_o | output | 1 | 0 sized read, 1 sized write |
| desc_posted_o | output | 1 | Posted channel |
| desc_pass_pw_o | output | 1 | Request may pass posted writes |
| desc_rsp_pass_pw_o | output | 1 | Response may pass posted writes |

## Verification
The bench builds the block with its defaults: 28 graphics tags, a reserved tag of 28 and 5-bit unit IDs. At these values a single burst of reads, with no responses returned, exhausts the rotation, so the full-stall and wrap boundaries come within a few dozen cycles. A later phase sets the base unit ID to 30, which makes base+1 and base+2 wrap through zero. Random traffic then mixes legal returns with stale and out-of-range tags.

// File: rtl/up_map_pkg.sv
package up_map_pkg;
  typedef enum logic [1:0] {
    REQ_HP_RD    = 2'd0,
    REQ_HP_WR    = 2'd1,
    REQ_LP_FENCE = 2'd2,
    REQ_PCI_NP   = 2'd3
  } req_kind_e;

  typedef enum logic {
    CMD_RD_SIZED = 1'b0,
    CMD_WR_SIZED = 1'b1
  } link_cmd_e;

  typedef struct packed {
    link_cmd_e cmd;
    logic      posted;
    logic      pass_pw;
    logic      rsp_pass_pw;
  } link_flags_t;
endpackage

// File: rtl/up_map_tag_ctr.sv
module up_map_tag_ctr #(
  parameter int unsigned NUM_TAGS = 28,
  parameter int unsigned TAG_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [TAG_W-1:0] tag_o
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(NUM_TAGS - 1);

  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tag_q <= '0;
    else if (adv_i) tag_q <= (tag_q == LAST) ? '0 : tag_q + 1'b1;
  end

  assign tag_o = tag_q;

  a_r1_tag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o <= LAST);
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && tag_o == LAST) |=> tag_o == '0);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(tag_o));
endmodule

// File: rtl/up_map_track.sv
module up_map_track #(
  parameter int unsigned NUM_SLOTS = 29,
  parameter int unsigned TAG_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [TAG_W-1:0]     set_tag_i,
  input  logic                 clr_i,
  input  logic [TAG_W-1:0]     clr_tag_i,
  output logic [NUM_SLOTS-1:0] busy_o,
  output logic                 err_o
);
  logic [NUM_SLOTS-1:0] busy_q;
  logic                 clr_in_range, clr_hit, err_q;

  assign clr_in_range = 32'(clr_tag_i) < NUM_SLOTS;
  assign clr_hit      = clr_i && clr_in_range && busy_q[clr_tag_i];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        busy_q[g] <= 1'b0;
      else if (set_i && 32'(set_tag_i) == g)
        busy_q[g] <= 1'b1;
      else if (clr_hit && 32'(clr_tag_i) == g)
        busy_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= clr_i && !clr_hit;
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  a_r2_set_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !busy_q[set_tag_i]);
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(clr_i));
  a_r8_err_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !clr_hit && !set_i) |=> $stable(busy_q));
endmodule

// File: rtl/up_map_xlate.sv
module up_map_xlate
  import up_map_pkg::*;
#(
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned UID_W   = 5,
  parameter int unsigned PCI_TAG = 28
) (
  input  req_kind_e         kind_i,
  input  logic [UID_W-1:0]  base_uid_i,
  input  logic [TAG_W-1:0]  gfx_tag_i,
  output logic [UID_W-1:0]  uid_o,
  output logic [TAG_W-1:0]  tag_o,
  output link_flags_t       flags_o,
  output logic              emits_o
);
  always_comb begin
    uid_o   = base_uid_i + UID_W'(2);
    tag_o   = '0;
    flags_o = '{cmd: CMD_RD_SIZED, posted: 1'b0, pass_pw: 1'b0, rsp_pass_pw: 1'b0};
    emits_o = 1'b1;
    unique case (kind_i)
      REQ_HP_RD: begin
        tag_o   = gfx_tag_i;
        flags_o = '{cmd: CMD_RD_SIZED, posted: 1'b0, pass_pw: 1'b1, rsp_pass_pw: 1'b1};
      end
      REQ_HP_WR: begin
        flags_o = '{cmd: CMD_WR_SIZED, posted: 1'b1, pass_pw: 1'b1, rsp_pass_pw: 1'b0};
      end
      REQ_PCI_NP: begin
        uid_o = base_uid_i + UID_W'(1);
        tag_o = TAG_W'(PCI_TAG);
      end
      default: emits_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/up_req_mapper.sv
module up_req_mapper
  import up_map_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 28,
  parameter int unsigned UID_W    = 5,
  parameter int unsigned TAG_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [UID_W-1:0] base_uid_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  output logic             req_ready_o,
  input  logic             rsp_valid_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  output logic             rsp_err_o,
  output logic             desc_valid_o,
  input  logic             desc_ready_i,
  output logic [UID_W-1:0] desc_uid_o,
  output logic [TAG_W-1:0] desc_tag_o,
  output logic             desc_cmd_o,
  output logic             desc_posted_o,
  output logic             desc_pass_pw_o,
  output logic             desc_rsp_pass_pw_o
);
  localparam int unsigned NUM_SLOTS = NUM_TAGS + 1;
  localparam int unsigned PCI_TAG   = NUM_TAGS;

  req_kind_e            kind;
  logic [TAG_W-1:0]     gfx_tag, xl_tag;
  logic [UID_W-1:0]     xl_uid;
  link_flags_t          xl_flags;
  logic                 xl_emits;
  logic [NUM_SLOTS-1:0] busy;
  logic                 slot_free, fire, load, take_tag;

  logic                 dv_q;
  logic [UID_W-1:0]     uid_q;
  logic [TAG_W-1:0]     tag_q;
  link_flags_t          flags_q;

  assign kind = req_kind_e'(req_kind_i);

  up_map_tag_ctr #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_tag_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fire && kind == REQ_HP_RD),
    .tag_o  (gfx_tag)
  );

  up_map_xlate #(.TAG_W(TAG_W), .UID_W(UID_W), .PCI_TAG(PCI_TAG)) u_xlate (
    .kind_i     (kind),
    .base_uid_i (base_uid_i),
    .gfx_tag_i  (gfx_tag),
    .uid_o      (xl_uid),
    .tag_o      (xl_tag),
    .flags_o    (xl_flags),
    .emits_o    (xl_emits)
  );

  up_map_track #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (fire && take_tag),
    .set_tag_i (xl_tag),
    .clr_i     (rsp_valid_i),
    .clr_tag_i (rsp_tag_i),
    .busy_o    (busy),
    .err_o     (rsp_err_o)
  );

  assign slot_free = !dv_q || desc_ready_i;
  assign take_tag  = (kind == REQ_HP_RD) || (kind == REQ_PCI_NP);

  always_comb begin
    unique case (kind)
      REQ_HP_RD:    req_ready_o = slot_free && !busy[gfx_tag];
      REQ_HP_WR:    req_ready_o = slot_free;
      REQ_PCI_NP:   req_ready_o = slot_free && !busy[PCI_TAG];
      default:      req_ready_o = (busy == '0);
    endcase
  end

  assign fire = req_valid_i && req_ready_o;
  assign load = fire && xl_emits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q    <= 1'b0;
      uid_q   <= '0;
      tag_q   <= '0;
      flags_q <= '0;
    end else if (load) begin
      dv_q    <= 1'b1;
      uid_q   <= xl_uid;
      tag_q   <= xl_tag;
      flags_q <= xl_flags;
    end else if (desc_ready_i) begin
      dv_q    <= 1'b0;
    end
  end

  assign desc_valid_o       = dv_q;
  assign desc_uid_o         = uid_q;
  assign desc_tag_o         = tag_q;
  assign desc_cmd_o         = flags_q.cmd;
  assign desc_posted_o      = flags_q.posted;
  assign desc_pass_pw_o     = flags_q.pass_pw;
  assign desc_rsp_pass_pw_o = flags_q.rsp_pass_pw;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=> desc_valid_o && $stable(desc_tag_o)
      && $stable(desc_uid_o) && $stable(desc_cmd_o) && $stable(desc_posted_o));
  a_r7_fence_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && kind == REQ_LP_FENCE && !desc_valid_o) |=> !desc_valid_o);
  a_r5_posted_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_posted_o) |-> desc_cmd_o && desc_pass_pw_o && !desc_rsp_pass_pw_o);
  a_r3_pci_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_tag_o == TAG_W'(PCI_TAG)) |-> !desc_pass_pw_o && !desc_posted_o);
  a_r2_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy[NUM_TAGS-1:0] == '1 && kind == REQ_HP_RD) |-> !req_ready_o);
endmodule

// File: tb/up_req_mapper_bench.sv
module up_req_mapper_bench;
  localparam int NT = 28;
  localparam int TW = 5;
  localparam int UW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [UW-1:0] base_uid = 5'd8;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'd0;
  logic          req_ready;
  logic          rsp_valid = 1'b0;
  logic [TW-1:0] rsp_tag = '0;
  logic          rsp_err;
  logic          dv;
  logic          d_ready = 1'b0;
  logic [UW-1:0] d_uid;
  logic [TW-1:0] d_tag;
  logic          d_cmd, d_posted, d_pass, d_rpass;

  always #10 clk = ~clk;

  up_req_mapper u_up_req_mapper (
    .clk_i(clk), .rst_ni(rst_n), .base_uid_i(base_uid),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_ready_o(req_ready),
    .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .rsp_err_o(rsp_err),
    .desc_valid_o(dv), .desc_ready_i(d_ready), .desc_uid_o(d_uid),
    .desc_tag_o(d_tag), .desc_cmd_o(d_cmd), .desc_posted_o(d_posted),
    .desc_pass_pw_o(d_pass), .desc_rsp_pass_pw_o(d_rpass)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  bit [NT:0] m_busy = '0;
  int        m_ntag = 0;
  bit        m_err = 1'b0;
  bit        s_v = 1'b0;
  int        s_uid, s_tag, s_cmd, s_posted, s_pass, s_rpass;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int k, input bit dr);
    bit free = !s_v || dr;
    case (k)
      0:       return free && !m_busy[m_ntag];
      1:       return free;
      3:       return free && !m_busy[NT];
      default: return m_busy == '0;
    endcase
  endfunction

  task automatic step(input bit v, input int k, input bit dr, input bit rv, input int rt);
    bit er, hit;
    @(negedge clk);
    req_valid = v; req_kind = 2'(k); d_ready = dr; rsp_valid = rv; rsp_tag = TW'(rt);
    #1;
    check(rsp_err == m_err, "R8 err pulse", int'(rsp_err), int'(m_err));
    er = exp_ready(k, dr);
    if (v) begin
      case (k)
        0: check(req_ready == er, "R2 read ready", int'(req_ready), int'(er));
        1: check(req_ready == er, "R9 write ready", int'(req_ready), int'(er));
        2: check(req_ready == er, "R7 fence ready", int'(req_ready), int'(er));
        default: check(req_ready == er, "R3 pci ready", int'(req_ready), int'(er));
      endcase
    end
    check(dv == s_v, "R9 desc valid", int'(dv), int'(s_v));
    if (s_v) begin
      check(int'(d_uid) == s_uid, "R4 uid", int'(d_uid), s_uid);
      check(int'(d_tag) == s_tag, "R1 tag", int'(d_tag), s_tag);
      check(int'(d_cmd) == s_cmd && int'(d_posted) == s_posted, "R5 cmd/posted",
            int'({d_cmd, d_posted}), (s_cmd << 1) | s_posted);
      check(int'(d_pass) == s_pass && int'(d_rpass) == s_rpass, "R6 pass flags",
            int'({d_pass, d_rpass}), (s_pass << 1) | s_rpass);
    end
    // model update for the coming edge
    hit = rv && rt <= NT && m_busy[rt];
    m_err = rv && !hit;
    if (hit) m_busy[rt] = 1'b0;
    if (s_v && dr) s_v = 1'b0;
    if (v && er && k != 2) begin
      s_v = 1'b1;
      s_uid = int'(UW'(base_uid + 5'd2));
      s_tag = 0; s_cmd = 0; s_posted = 0; s_pass = 1; s_rpass = 1;
      if (k == 0) begin
        s_tag = m_ntag; m_busy[m_ntag] = 1'b1; m_ntag = (m_ntag + 1) % NT;
      end else if (k == 1) begin
        s_cmd = 1; s_posted = 1; s_rpass = 0;
      end else begin
        s_uid = int'(UW'(base_uid + 5'd1));
        s_tag = NT; s_pass = 0; s_rpass = 0; m_busy[NT] = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); #1;
    check(dv == 1'b0, "R9 reset desc", int'(dv), 0);
    check(rsp_err == 1'b0, "R9 reset err", int'(rsp_err), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2: burst of reads until the rotation is exhausted
    for (int i = 0; i < 32; i++) step(1, 0, 1, 0, 0);
    check(req_ready == 1'b0, "R2 full stall", int'(req_ready), 0);
    // R5: write passes while reads are outstanding; R7 fence blocked
    step(1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 2, 1, 0, 0);
    // R3: one PCI request, a second stalls
    step(1, 3, 1, 0, 0);
    step(1, 3, 1, 0, 0);
    step(1, 3, 1, 0, 0);
    // R2: return tag 0, next read (tag 0) proceeds after it
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0);
    // R8: return everything, then stale and out-of-range tags
    for (int t = 0; t <= NT; t++) step(0, 0, 1, 1, t);
    step(0, 0, 1, 1, 3);
    step(0, 0, 1, 1, 30);
    step(0, 0, 1, 0, 0);
    // R7: fence accepted now, no descriptor follows
    step(1, 2, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R9: stalled descriptor holds and blocks further requests
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    for (int t = 0; t <= NT; t++) step(0, 0, 1, 1, t);
    step(0, 0, 1, 0, 0);
    // R4: base near the top so base+1/base+2 wrap
    base_uid = 5'd30;
    for (int i = 0; i < 6000; i++) begin
      int rt;
      rt = ($urandom % 10 == 0) ? int'($urandom % 32) : int'($urandom % (NT + 1));
      step(($urandom % 10) < 7, int'($urandom % 4), ($urandom % 4) != 0,
           ($urandom % 3) == 0, rt);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule